// File: doc/BRIEF.md
# Partition Step Solver: Pipelined Fixed-Point Matrix-Vector Engine

This block produces, once per simulation step, the full output vector of one decoupled circuit partition. The vector holds the node voltages in its first rows and the branch currents in the rows after them. The block forms it as a single precomputed product. A history coefficient matrix multiplies the history-current vector from the previous step, and a source coefficient matrix multiplies the source equivalent-current vector. There is no intermediate injection-current stage. The coefficients are written into per-row storage at initialisation. The input vector entries are written into a shared vector store before each step.

Each output row has its own multiplier lane. The columns of both matrices are presented serially, one column per cycle, so a step costs one cycle per column plus a fixed pipeline depth. Each lane forms a 25-bit by 18-bit signed product and adds it into a wide accumulator. At the end of the step every accumulator is rounded and saturated back to a 25-bit value with 12 fractional bits. A start pulse launches a step. A one-cycle done pulse marks the moment the new results are valid. The number of rows, the history and source column counts and the number widths are parameters, so each partition is a separate instance.

Top module: `mvm_step_engine`

## Requirements
- R1: After reset, busy and done are 0 and every result row reads 0.
- R2: A start seen while idle sets busy on the next clock edge. Done is a single-cycle pulse that rises on the edge NCOL+3 edges after the accepting edge, where NCOL = NHIST + NSRC. Busy falls on that same edge.
- R3: Result row r is the sum over column c of coef[r][c] * vec[c], taken over all NCOL columns. Columns 0..NHIST-1 hold the history matrix and pair with vector entries 0..NHIST-1. Columns NHIST..NCOL-1 hold the source matrix and pair with vector entries NHIST..NCOL-1.
- R4: Coefficients carry CFRAC = 12 fractional bits and vector entries carry 12. The exact sum is scaled back by adding 2^(CFRAC-1) and then shifting arithmetically right by CFRAC bits, so halves round toward positive infinity.
- R5: A scaled sum above 2^24-1 reads as 2^24-1. A scaled sum below -2^24 reads as -2^24.
- R6: A start pulse that arrives while busy is ignored. Done still comes at the time set by the first start, and no extra done follows.
- R7: The accumulators are cleared at every accepted start. Repeating a step with unchanged data gives identical results.
- R8: Results are read by placing the row number on rd_row, and rd_data shows that row combinationally. Rows 0..NODES-1 are node voltages and rows NODES..ROWS-1 are branch currents. Results change only on the edge where done rises. Vector or coefficient writes made while idle leave them untouched until the next step ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cw_en | input | 1 | Coefficient write enable |
| cw_row | input | RIW | Coefficient row (output lane) |
| cw_col | input | CIW | Coefficient column (history first, then source) |
| cw_data | input | CW | Signed coefficient, 12 fractional bits |
| vw_en | input | 1 | Vector write enable |
| vw_idx | input | CIW | Vector entry index |
| vw_data | input | XW | Signed vector entry, 12 fractional bits |
| start | input | 1 | Step launch pulse |
| busy | output | 1 | Step in progress |
| done | output | 1 | One-cycle pulse, results updated |
| rd_row | input | RIW | Result row select |
| rd_data | output | XW | Selected result row |

## Verification
The bench builds the engine with its default size: 8 node rows plus 13 branch rows make 21 lanes, and 13 history columns plus 3 source columns make 16 columns. That is the largest partition shape, with a latency of 19 cycles. With 16 columns, full-scale coefficients and inputs drive the sum far past the 25-bit range in both directions, so both saturation limits can be reached. Single coefficients of 1, -1, 3 and -3 expose each rounding direction at the half point. Random seeded matrices with moderate magnitudes check the exact sum across all lanes and both column groups.

// File: rtl/mvm_pkg.sv
package mvm_pkg;

  // Scale an exact product sum back by frac bits, rounding halves upward.
  function automatic longint rnd_shift(input longint a, input int frac);
    longint half;
    half = longint'(1) <<< (frac - 1);
    return (a + half) >>> frac;
  endfunction

  // Clamp to the range of a w-bit two's complement number.
  function automatic longint sat_to(input longint v, input int w);
    longint hi;
    longint lo;
    hi = (longint'(1) <<< (w - 1)) - 1;
    lo = -(longint'(1) <<< (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

endpackage

// File: rtl/mvm_seq.sv
module mvm_seq #(
  parameter int NCOL = 16,
  localparam int CIW = (NCOL > 1) ? $clog2(NCOL) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  output logic           busy,
  output logic           done,
  output logic           acc_clr,
  output logic           rd_en,
  output logic [CIW-1:0] rd_col,
  output logic           mul_en,
  output logic           acc_en,
  output logic           res_en
);
  localparam logic [CIW-1:0] LASTC = CIW'(NCOL - 1);

  logic           run_q;
  logic [CIW-1:0] col_q;
  logic           v1_q, v2_q, l1_q, l2_q, wr_q, busy_q, done_q;
  logic           accept;

  assign accept = start && !busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      col_q  <= '0;
      v1_q   <= 1'b0;
      v2_q   <= 1'b0;
      l1_q   <= 1'b0;
      l2_q   <= 1'b0;
      wr_q   <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (accept) begin
        run_q  <= 1'b1;
        col_q  <= '0;
        busy_q <= 1'b1;
      end else if (run_q) begin
        col_q <= col_q + 1'b1;
        if (col_q == LASTC) run_q <= 1'b0;
      end
      v1_q   <= run_q;
      l1_q   <= run_q && (col_q == LASTC);
      v2_q   <= v1_q;
      l2_q   <= l1_q;
      wr_q   <= l2_q;
      done_q <= wr_q;
      if (wr_q) busy_q <= 1'b0;
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign acc_clr = accept;
  assign rd_en   = run_q;
  assign rd_col  = col_q;
  assign mul_en  = v1_q;
  assign acc_en  = v2_q;
  assign res_en  = wr_q;
endmodule

// File: rtl/mvm_vec_store.sv
module mvm_vec_store #(
  parameter int NCOL = 16,
  parameter int XW   = 25,
  localparam int CIW = (NCOL > 1) ? $clog2(NCOL) : 1
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic [CIW-1:0]       wr_idx,
  input  logic signed [XW-1:0] wr_data,
  input  logic                 rd_en,
  input  logic [CIW-1:0]       rd_idx,
  output logic signed [XW-1:0] x_q
);
  logic signed [XW-1:0] mem [NCOL];

  always_ff @(posedge clk) begin
    if (wr_en && (int'(wr_idx) < NCOL)) mem[wr_idx] <= wr_data;
    if (rd_en) x_q <= mem[rd_idx];
  end
endmodule

// File: rtl/mvm_lane.sv
module mvm_lane #(
  parameter int NCOL  = 16,
  parameter int XW    = 25,
  parameter int CW    = 18,
  parameter int CFRAC = 12,
  localparam int CIW  = (NCOL > 1) ? $clog2(NCOL) : 1,
  localparam int PW   = XW + CW,
  localparam int AW   = PW + CIW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cw_en,
  input  logic [CIW-1:0]       cw_col,
  input  logic signed [CW-1:0] cw_data,
  input  logic                 rd_en,
  input  logic [CIW-1:0]       rd_col,
  input  logic signed [XW-1:0] x_q,
  input  logic                 mul_en,
  input  logic                 acc_clr,
  input  logic                 acc_en,
  input  logic                 res_en,
  output logic signed [XW-1:0] res
);
  logic signed [CW-1:0] mem [NCOL];
  logic signed [CW-1:0] c_q;
  logic signed [PW-1:0] prod_q;
  logic signed [AW-1:0] acc_q;
  logic signed [XW-1:0] res_q;

  // Row coefficient storage with a registered read port.
  always_ff @(posedge clk) begin
    if (cw_en && (int'(cw_col) < NCOL)) mem[cw_col] <= cw_data;
    if (rd_en) c_q <= mem[rd_col];
  end

  // Multiply stage.
  always_ff @(posedge clk) begin
    if (!rst_n) prod_q <= '0;
    else if (mul_en) prod_q <= PW'(c_q) * PW'(x_q);
  end

  // Accumulate stage, cleared on every accepted start.
  always_ff @(posedge clk) begin
    if (!rst_n) acc_q <= '0;
    else if (acc_clr) acc_q <= '0;
    else if (acc_en) acc_q <= acc_q + AW'(prod_q);
  end

  // Rescale and hold the result until the next step completes.
  always_ff @(posedge clk) begin
    if (!rst_n) res_q <= '0;
    else if (res_en)
      res_q <= XW'(mvm_pkg::sat_to(mvm_pkg::rnd_shift(longint'(acc_q), CFRAC), XW));
  end

  assign res = res_q;
endmodule

// File: rtl/mvm_step_engine.sv
module mvm_step_engine #(
  parameter int NODES    = 8,
  parameter int BRANCHES = 13,
  parameter int NHIST    = 13,
  parameter int NSRC     = 3,
  parameter int XW       = 25,
  parameter int CW       = 18,
  parameter int CFRAC    = 12,
  localparam int ROWS    = NODES + BRANCHES,
  localparam int NCOL    = NHIST + NSRC,
  localparam int RIW     = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CIW     = (NCOL > 1) ? $clog2(NCOL) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cw_en,
  input  logic [RIW-1:0]       cw_row,
  input  logic [CIW-1:0]       cw_col,
  input  logic signed [CW-1:0] cw_data,
  input  logic                 vw_en,
  input  logic [CIW-1:0]       vw_idx,
  input  logic signed [XW-1:0] vw_data,
  input  logic                 start,
  output logic                 busy,
  output logic                 done,
  input  logic [RIW-1:0]       rd_row,
  output logic signed [XW-1:0] rd_data
);
  logic           acc_clr, rd_en, mul_en, acc_en, res_en;
  logic [CIW-1:0] rd_col;
  logic signed [XW-1:0] x_q;
  logic signed [XW-1:0] res_arr [ROWS];

  mvm_seq #(.NCOL(NCOL)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .acc_clr(acc_clr), .rd_en(rd_en), .rd_col(rd_col), .mul_en(mul_en),
    .acc_en(acc_en), .res_en(res_en)
  );

  mvm_vec_store #(.NCOL(NCOL), .XW(XW)) u_vec (
    .clk(clk), .wr_en(vw_en), .wr_idx(vw_idx), .wr_data(vw_data),
    .rd_en(rd_en), .rd_idx(rd_col), .x_q(x_q)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_lane
    logic lane_we;
    assign lane_we = cw_en && (cw_row == RIW'(r));
    mvm_lane #(.NCOL(NCOL), .XW(XW), .CW(CW), .CFRAC(CFRAC)) u_lane (
      .clk(clk), .rst_n(rst_n), .cw_en(lane_we), .cw_col(cw_col),
      .cw_data(cw_data), .rd_en(rd_en), .rd_col(rd_col), .x_q(x_q),
      .mul_en(mul_en), .acc_clr(acc_clr), .acc_en(acc_en),
      .res_en(res_en), .res(res_arr[r])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int r = 0; r < ROWS; r++)
      if (rd_row == RIW'(r)) rd_data = res_arr[r];
  end
endmodule

// File: rtl/mvm_step_engine_chk.sv
module mvm_step_engine_chk #(
  parameter int NCOL = 16,
  parameter int RIW  = 5,
  parameter int XW   = 25
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic [RIW-1:0] rd_row,
  input logic [XW-1:0]  rd_data
);
  logic [15:0] lat_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) lat_cnt <= '0;
    else if (start && !busy) lat_cnt <= '0;
    else if (busy && lat_cnt != 16'hFFFF) lat_cnt <= lat_cnt + 1'b1;
  end

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R6
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_cnt == 16'(NCOL + 3)));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && $stable(rd_row)) |-> $stable(rd_data));
endmodule

bind mvm_step_engine mvm_step_engine_chk #(.NCOL(NCOL), .RIW(RIW), .XW(XW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .rd_row(rd_row), .rd_data(rd_data)
);

// File: tb/test_mvm_step_engine.sv
module test_mvm_step_engine;
  localparam int CLK_PERIOD = 10;
  localparam int NODES = 8, BRANCHES = 13, NHIST = 13, NSRC = 3;
  localparam int XW = 25, CW = 18;
  localparam int ROWS = NODES + BRANCHES;
  localparam int NCOL = NHIST + NSRC;
  localparam int RIW = $clog2(ROWS);
  localparam int CIW = $clog2(NCOL);
  localparam int LAT = NCOL + 3;

  logic clk = 0, rst_n = 0;
  logic cw_en = 0, vw_en = 0, start = 0;
  logic [RIW-1:0] cw_row = '0, rd_row = '0;
  logic [CIW-1:0] cw_col = '0, vw_idx = '0;
  logic signed [CW-1:0] cw_data = '0;
  logic signed [XW-1:0] vw_data = '0;
  logic busy, done;
  logic signed [XW-1:0] rd_data;

  int n_chk = 0, n_fail = 0;
  int coef [ROWS][NCOL];
  int vec  [NCOL];

  always #(CLK_PERIOD/2) clk = ~clk;

  mvm_step_engine i_mvm_step_engine (
    .clk(clk), .rst_n(rst_n), .cw_en(cw_en), .cw_row(cw_row), .cw_col(cw_col),
    .cw_data(cw_data), .vw_en(vw_en), .vw_idx(vw_idx), .vw_data(vw_data),
    .start(start), .busy(busy), .done(done), .rd_row(rd_row), .rd_data(rd_data)
  );

  task automatic check(input string req, input longint got, input longint exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic longint expect_row(input int r);
    longint s = 0;
    for (int c = 0; c < NCOL; c++) s += longint'(coef[r][c]) * longint'(vec[c]);
    s = (s + 2048) >>> 12;
    if (s > 16777215) s = 16777215;
    if (s < -16777216) s = -16777216;
    return s;
  endfunction

  task automatic load_all();
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < NCOL; c++) begin
        @(negedge clk);
        cw_en = 1; cw_row = RIW'(r); cw_col = CIW'(c); cw_data = CW'(coef[r][c]);
      end
    for (int c = 0; c < NCOL; c++) begin
      @(negedge clk);
      cw_en = 0; vw_en = 1; vw_idx = CIW'(c); vw_data = XW'(vec[c]);
    end
    @(negedge clk);
    cw_en = 0; vw_en = 0;
  endtask

  task automatic load_vec();
    for (int c = 0; c < NCOL; c++) begin
      @(negedge clk);
      vw_en = 1; vw_idx = CIW'(c); vw_data = XW'(vec[c]);
    end
    @(negedge clk);
    vw_en = 0;
  endtask

  // Launch a step, optionally with a second start mid-run; check timing.
  task automatic run_step(input string req, input bit restart);
    int n = 0;
    @(negedge clk); start = 1;
    @(posedge clk); #1;
    check("R2 busy after start", busy, 1);
    @(negedge clk); start = 0;
    while (n < 4 * LAT) begin
      if (restart && n == 5) begin
        @(negedge clk); start = 1;
        @(posedge clk); n++; #1;
        @(negedge clk); start = 0;
        if (done) break;
        continue;
      end
      @(posedge clk); n++; #1;
      if (done) break;
    end
    check({req, " latency"}, n, LAT);
    check("R2 busy low at done", busy, 0);
    @(posedge clk); #1;
    check("R2 done one cycle", done, 0);
  endtask

  task automatic check_rows(input string req);
    for (int r = 0; r < ROWS; r++) begin
      @(negedge clk); rd_row = RIW'(r); #1;
      check(req, rd_data, expect_row(r));
    end
  endtask

  function automatic int rnd(input int span);
    return int'($urandom_range(0, 2 * span)) - span;
  endfunction

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    for (int r = 0; r < ROWS; r++) begin
      rd_row = RIW'(r); #1;
      check("R1 result zero", rd_data, 0);
    end

    // R4 rounding at the half point in both directions
    for (int r = 0; r < ROWS; r++) for (int c = 0; c < NCOL; c++) coef[r][c] = 0;
    for (int c = 0; c < NCOL; c++) vec[c] = 0;
    vec[0] = 2048;
    coef[0][0] = 1; coef[1][0] = -1; coef[2][0] = 3; coef[3][0] = -3;
    load_all();
    run_step("R2", 0);
    check_rows("R4 rounding");
    rd_row = 0; #1; check("R4 +0.5 -> 1", rd_data, 1);
    rd_row = 1; #1; check("R4 -0.5 -> 0", rd_data, 0);
    rd_row = 2; #1; check("R4 +1.5 -> 2", rd_data, 2);
    rd_row = 3; #1; check("R4 -1.5 -> -1", rd_data, -1);

    // R5 saturation both ways; row 2 checks the source columns alone
    for (int r = 0; r < ROWS; r++) for (int c = 0; c < NCOL; c++) coef[r][c] = 0;
    for (int c = 0; c < NCOL; c++) begin
      vec[c] = 16777215;
      coef[0][c] = 131071;
      coef[1][c] = -131072;
    end
    for (int j = 0; j < NSRC; j++) coef[2][NHIST + j] = 4096;
    load_all();
    run_step("R2", 0);
    rd_row = 0; #1; check("R5 positive clamp", rd_data, 16777215);
    rd_row = 1; #1; check("R5 negative clamp", rd_data, -16777216);
    check_rows("R3 source columns / R5");

    // R3 random matrices and vectors
    for (int k = 0; k < 3; k++) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < NCOL; c++) coef[r][c] = rnd(16384);
      for (int c = 0; c < NCOL; c++) vec[c] = rnd(65536);
      load_all();
      run_step("R2", 0);
      check_rows("R3 random");
    end

    // R8 idle vector writes do not disturb held results
    for (int c = 0; c < NCOL; c++) vec[c] = rnd(65536);
    for (int r = 0; r < ROWS; r++) begin
      @(negedge clk); rd_row = RIW'(r); #1;
    end
    begin
      longint held0, held_last;
      rd_row = 0; #1; held0 = rd_data;
      rd_row = RIW'(ROWS - 1); #1; held_last = rd_data;
      load_vec();
      rd_row = 0; #1; check("R8 row 0 held", rd_data, held0);
      rd_row = RIW'(ROWS - 1); #1; check("R8 last row held", rd_data, held_last);
    end

    // R7 repeated step with unchanged data
    run_step("R7", 0);
    check_rows("R7 first");
    run_step("R7", 0);
    check_rows("R7 repeat");

    // R6 start while busy is ignored
    for (int c = 0; c < NCOL; c++) vec[c] = rnd(65536);
    load_vec();
    run_step("R6", 1);
    begin
      int extra = 0;
      for (int i = 0; i < LAT + 6; i++) begin
        @(posedge clk); #1;
        if (done) extra++;
      end
      check("R6 no extra done", extra, 0);
    end
    check_rows("R6 results");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule